// File: doc/BRIEF.md
# Mono Sample I2S Transmitter

This block drives a stereo audio DAC over a three-wire I2S link: a bit clock, a word-select (channel) clock and one serial data line. All three come from the fast system clock through counter-based clock enables, so the whole block sits in a single clock domain. The feeding logic supplies one 16-bit two's complement mono sample. The transmitter captures it once per frame and sends the same word in both the left and the right channel slot.

Each channel slot is 16 bit-clock periods long, so one frame is 32 bit-clock periods. The word-select line is low for the left slot and high for the right slot. The data line changes only when the bit clock falls, so the DAC can sample it on the rising edge. Each word starts one bit-clock period after the word-select edge: its MSB appears in the second period of the slot, and its LSB appears in the first period of the following slot. A one-cycle strobe tells the feeder when a sample has been captured. The feeder may change its input at any time without corrupting the frame in flight.

With the default divider of 16 and a 50 MHz system clock, the bit clock is 1.5625 MHz and the frame rate is about 48.8 kHz.

Top module: `i2s_mono_tx`

## Requirements
- R1: While reset is high, and in the first system cycle after it, `bclk`, `lrclk`, `sdata` and `sample_req` are all low.
- R2: `bclk` is a square wave with a period of exactly 2×HALF_DIV system cycles, high for HALF_DIV cycles and low for HALF_DIV cycles.
- R3: `lrclk` changes only in the system cycle in which `bclk` falls. It stays constant for exactly 16 rising `bclk` edges per slot, and it is low during the left slot.
- R4: `sdata` changes only in the system cycle in which `bclk` falls.
- R5: A word is sent MSB first. Its MSB is on the second rising `bclk` edge after an `lrclk` change, and its LSB is on the first rising edge after the next `lrclk` change.
- R6: The right-slot word of a frame is bit-identical to the left-slot word of the same frame.
- R7: The sample is captured from `sample_in` in the system cycle in which `lrclk` falls to start a frame. `sample_req` is high for exactly that one cycle. Any change of `sample_in` after that cycle has no effect on the words of that frame.
- R8: The sample bits are sent unaltered in two's complement form. 0x8000 (most negative) and 0x7FFF (most positive) appear on the line as 1 followed by fifteen 0s, and as 0 followed by fifteen 1s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 16 | Mono sample, two's complement |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Channel select, low = left, high = right |
| sdata | output | 1 | Serial data, MSB first, one-bit delayed |
| sample_req | output | 1 | One-cycle strobe when `sample_in` is captured |

## Verification
The hardest case to reach from the ports is a change of `sample_in` while a frame is being sent. It has to arrive after the capture strobe but before both slots are out, so that a wrong design would visibly send the new value in the right slot. The stimulus waits for `sample_req`, waits part of a frame, and then drives the bitwise inverse of the captured value. The bench then decodes both slots purely from the line's edges, with the one-bit delay applied, and compares them with the value that was present at the strobe.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int SAMPLE_W = 16;

    typedef logic [SAMPLE_W-1:0] sample_t;

    // strobes for the bit-clock edge that the next system edge produces
    typedef struct packed {
        logic rise;
        logic fall;
    } bclk_edge_t;

    // slot events, valid in the cycle of a falling bit-clock edge
    typedef struct packed {
        logic advance;      // any falling edge
        logic frame_start;  // counter wraps to the first period of the left slot
        logic word_start;   // second period of either slot: MSB goes out
        logic lr_next;      // word-select level after this edge
    } slot_evt_t;

    function automatic logic is_word_start(input int unsigned pos, input int unsigned slot_bits);
        return (pos == 1) || (pos == slot_bits + 1);
    endfunction

endpackage

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen
    import i2s_tx_pkg::*;
#(
    parameter int HALF_DIV = 16
) (
    input  logic       clk,
    input  logic       rst,
    output logic       bclk,
    output bclk_edge_t edge_o
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick        = (cnt == LAST);
    assign edge_o.rise = tick & ~bclk;
    assign edge_o.fall = tick & bclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    bclk_fall_chk: assert property (@(posedge clk) disable iff (rst) edge_o.fall |=> !bclk);
    // R2
    bclk_rise_chk: assert property (@(posedge clk) disable iff (rst) edge_o.rise |=> bclk);
    // R2
    bclk_hold_chk: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(bclk));

endmodule

// File: rtl/i2s_frame_ctr.sv
module i2s_frame_ctr
    import i2s_tx_pkg::*;
#(
    parameter int SLOT_BITS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  bclk_edge_t edge_i,
    output logic       lrclk,
    output slot_evt_t  evt
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] RIGHT_POS = CNT_W'(SLOT_BITS);

    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] pos_nxt;

    assign pos_nxt = (pos == LAST_POS) ? '0 : pos + 1'b1;

    always_comb begin
        evt.advance     = edge_i.fall;
        evt.frame_start = edge_i.fall && (pos_nxt == '0);
        evt.word_start  = edge_i.fall && is_word_start(32'(pos_nxt), SLOT_BITS);
        evt.lr_next     = (pos_nxt >= RIGHT_POS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= LAST_POS;
            lrclk <= 1'b0;
        end else if (edge_i.fall) begin
            pos   <= pos_nxt;
            lrclk <= evt.lr_next;
        end
    end

    // R3
    lr_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (lrclk != $past(lrclk)) |-> $past(edge_i.fall));
    // R3
    pos_step_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_i.fall |=> $stable(pos));
    // R3
    frame_low_chk: assert property (@(posedge clk) disable iff (rst)
        evt.frame_start |=> !lrclk);

endmodule

// File: rtl/i2s_word_shifter.sv
module i2s_word_shifter
    import i2s_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sample_t   sample_in,
    input  slot_evt_t evt,
    output logic      sdata,
    output logic      sample_req
);
    sample_t hold;
    sample_t shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold       <= '0;
            shreg      <= '0;
            sdata      <= 1'b0;
            sample_req <= 1'b0;
        end else begin
            sample_req <= evt.frame_start;
            if (evt.advance) begin
                if (evt.frame_start) begin
                    hold <= sample_in;
                end
                if (evt.word_start) begin
                    sdata <= hold[SAMPLE_W-1];
                    shreg <= {hold[SAMPLE_W-2:0], 1'b0};
                end else begin
                    sdata <= shreg[SAMPLE_W-1];
                    shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
                end
            end
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.frame_start |=> $stable(hold));
    // R7
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        sample_req |=> !sample_req);
    // R5
    msb_load_chk: assert property (@(posedge clk) disable iff (rst)
        evt.word_start |=> (sdata == $past(hold[SAMPLE_W-1])));

endmodule

// File: rtl/i2s_mono_tx.sv
module i2s_mono_tx
    import i2s_tx_pkg::*;
#(
    parameter int HALF_DIV  = 16,
    parameter int SLOT_BITS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] sample_in,
    output logic        bclk,
    output logic        lrclk,
    output logic        sdata,
    output logic        sample_req
);
    bclk_edge_t edge_s;
    slot_evt_t  evt_s;

    i2s_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
        .clk    (clk),
        .rst    (rst),
        .bclk   (bclk),
        .edge_o (edge_s)
    );

    i2s_frame_ctr #(.SLOT_BITS(SLOT_BITS)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .edge_i (edge_s),
        .lrclk  (lrclk),
        .evt    (evt_s)
    );

    i2s_word_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .sample_in  (sample_in),
        .evt        (evt_s),
        .sdata      (sdata),
        .sample_req (sample_req)
    );

    // R4
    sdata_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (sdata != $past(sdata)) |-> ($past(bclk) && !bclk));
    // R3
    lr_with_bclk_chk: assert property (@(posedge clk) disable iff (rst)
        (lrclk != $past(lrclk)) |-> ($past(bclk) && !bclk));
    // R7
    req_at_left_chk: assert property (@(posedge clk) disable iff (rst)
        sample_req |-> (!lrclk && !bclk));

endmodule

// File: tb/test_i2s_mono_tx.sv
module test_i2s_mono_tx;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] sample_in = 16'h0000;
    logic        bclk, lrclk, sdata, sample_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    i2s_mono_tx #(.HALF_DIV(HALF), .SLOT_BITS(16)) i_i2s_mono_tx (
        .clk        (clk),
        .rst        (rst),
        .sample_in  (sample_in),
        .bclk       (bclk),
        .lrclk      (lrclk),
        .sdata      (sdata),
        .sample_req (sample_req)
    );

    // line monitor and decoder
    logic [15:0] lw [0:63];
    logic [15:0] rw [0:63];
    int nl = 0, nr = 0, nreq = 0;
    int per_bad = 0, hi_bad = 0, lr_bad = 0, sd_bad = 0, slot_bad = 0, req_bad = 0;
    int rises = 0, slots = 0;
    int cyc = 0, hcyc = 0, rcnt = 0;
    bit seen_rise = 0, seen_change = 0;
    logic bclk_p = 0, lr_p = 0, sd_p = 0, req_p = 0, dlr = 0;
    logic [15:0] acc = '0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc  = cyc + 1;
            hcyc = hcyc + 1;
            if (lrclk != lr_p && !(bclk_p && !bclk)) lr_bad++;
            if (sdata != sd_p && !(bclk_p && !bclk)) sd_bad++;
            if (sample_req && (req_p || lrclk || bclk)) req_bad++;
            if (sample_req) nreq++;
            if (!bclk && bclk_p && seen_rise && hcyc != HALF) hi_bad++;
            if (bclk && !bclk_p) begin
                if (seen_rise && cyc != 2 * HALF) per_bad++;
                cyc = 0; hcyc = 0; seen_rise = 1; rises++;
                if (lrclk != dlr) begin
                    if (seen_change && rcnt != 16) slot_bad++;
                    seen_change = 1; slots++;
                    rcnt = 1;
                    if (dlr == 1'b0) begin
                        if (nl < 64) lw[nl] = {acc[14:0], sdata};
                        nl++;
                    end else begin
                        if (nr < 64) rw[nr] = {acc[14:0], sdata};
                        nr++;
                    end
                    acc = '0;
                    dlr = lrclk;
                end else begin
                    rcnt++;
                    acc = {acc[14:0], sdata};
                end
            end
        end
        bclk_p = bclk; lr_p = lrclk; sd_p = sdata; req_p = sample_req;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one sample, optionally disturb it mid-frame, check both slots
    task automatic send(input logic [15:0] v, input bit glitch, input string req);
        int idx;
        @(negedge clk);
        sample_in = v;
        do @(negedge clk); while (!sample_req);
        @(negedge clk);
        idx = nreq - 1;
        if (glitch) begin
            repeat (60) @(negedge clk);
            sample_in = ~v;
        end
        while (nr <= idx) @(negedge clk);
        if (idx < 64) begin
            chk(lw[idx] == v, {req, " left slot"}, 32'(lw[idx]), 32'(v));
            chk(rw[idx] == v, {req, " right slot R6"}, 32'(rw[idx]), 32'(v));
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk({bclk, lrclk, sdata, sample_req} == 4'b0, "R1 in reset", 32'({bclk, lrclk, sdata, sample_req}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({bclk, lrclk, sdata, sample_req} == 4'b0, "R1 after release", 32'({bclk, lrclk, sdata, sample_req}), 0);
    endtask

    task automatic t_patterns;
        send(16'hA5C3, 0, "R5 pattern");
        send(16'h1234, 0, "R5 pattern");
        send(16'h0001, 0, "R5 lsb only");
        send(16'hFEDC, 0, "R5 pattern");
    endtask

    task automatic t_extremes;
        send(16'h8000, 0, "R8 most negative");
        send(16'h7FFF, 0, "R8 most positive");
        send(16'h0000, 0, "R8 zero");
        send(16'hFFFF, 0, "R8 minus one");
    endtask

    task automatic t_midframe;
        send(16'h3C5A, 1, "R7 mid-frame change");
        send(16'hC001, 1, "R7 mid-frame change");
    endtask

    task automatic t_timing;
        chk(rises > 100 && per_bad == 0, "R2 bit clock period", 32'(per_bad), 0);
        chk(hi_bad == 0, "R2 bit clock high time", 32'(hi_bad), 0);
        chk(slots > 4 && slot_bad == 0, "R3 slot length", 32'(slot_bad), 0);
        chk(lr_bad == 0, "R3 lrclk edge timing", 32'(lr_bad), 0);
        chk(sd_bad == 0, "R4 sdata edge timing", 32'(sd_bad), 0);
        chk(nreq > 4 && req_bad == 0, "R7 capture strobe", 32'(req_bad), 0);
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_extremes();
        t_midframe();
        t_timing();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule